// File: doc/BRIEF.md
# Banked Word Memory Composer

This block builds one wide word memory from narrow byte-wide banks. The banks are arranged as two rows, and each row has four byte lanes. A single word address selects one word. Its top bit chooses the row whose banks are enabled. The remaining low bits go to every bank in parallel. Each bank in a row stores and returns one byte of the 32-bit word.

In the full-size configuration (`ADDR_W = 18`) the block holds 256K words from eight 128K x 8 banks. The default parameter value is smaller so that the behavioural storage stays compact. Writes complete at the clock edge. A read result comes back one cycle after the request is accepted.

The read path is modelled as a shared bus with explicit output-enable gating. A bank drives its byte lane only when three conditions hold: its row was selected, a read was accepted, and no write is in progress. When no bank drives the bus, it reads as zero. Whenever the write enable is high, every output driver is off.

Top module: `wide_word_store`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0 while no request is made.
- R2: A word written to an address is returned unchanged by a later read of that address, as long as no write to that address comes in between.
- R3: Addresses that differ only in the top address bit select different bank rows and hold independent words.
- R4: Every byte lane is stored by its own bank. Lane k holds bits [8k+7:8k] of the word, with k from 0 to 3. A word whose four bytes all differ returns each byte in its own position.
- R5: A read is accepted when `rd_en` is 1 and `wr_en` is 0. In the next cycle `rd_valid` is 1 and `rd_data` carries the word. In any cycle with no result, `rd_valid` is 0 and `rd_data` is 0.
- R6: If `rd_en` and `wr_en` are both 1 in the same cycle, the write is performed and the read is dropped. The following cycle shows `rd_valid` = 0.
- R7: While `wr_en` is 1, all bank outputs are disabled: `rd_data` is 0 and `rd_valid` is 0. This holds even when a read result is due in that cycle, and that result is lost. The write itself still takes effect.
- R8: In any cycle, banks of at most one row drive the data bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | ADDR_W | Word address; top bit selects the row |
| wr_en | input | 1 | Write strobe; also disables all output drivers |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Assembled read word; 0 when nothing drives the bus |
| rd_valid | output | 1 | High in the cycle a read result is on `rd_data` |

## Verification
Two kinds of collision matter here. A read request and a write can arrive in the same cycle. A read result can also fall due in the same cycle as a new write, in which case the output-enable gating must suppress it.

The bench provokes both cases in directed sequences. It also sets the random write and read probabilities high, so that back-to-back read-then-write pairs occur often. A reference model predicts the outcome: the write must land, and the read must be dropped or blanked. The bench then reads the written address again to confirm the store.

// File: rtl/wws_pkg.sv
package wws_pkg;
    localparam int LANE_W = 8;

    typedef struct packed {
        logic pend;   // a read was accepted last cycle
    } ctl_t;
endpackage

// File: rtl/row_select.sv
module row_select #(
    parameter int ROWS  = 2,
    parameter int SEL_W = 1
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             active,
    output logic [ROWS-1:0]  cs
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign cs[r] = active && (sel == SEL_W'(r));
    end
endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
    parameter int AW = 9,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic          oe,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  lane,
    output logic          drive
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];
    logic [W-1:0] dq_q;
    logic         en_q;

    always_ff @(posedge clk) begin
        if (cs && we) cells[addr] <= din;
    end

    always_ff @(posedge clk) begin
        if (cs && oe && !we) dq_q <= cells[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= cs && oe && !we;
    end

    // the live write strobe turns the driver off for the whole write
    assign drive = en_q && !we;
    assign lane  = drive ? dq_q : '0;
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
    parameter int ROWS  = 2,
    parameter int LANES = 4,
    parameter int W     = 8
) (
    input  logic [ROWS-1:0][LANES-1:0][W-1:0] lanes,
    output logic [LANES*W-1:0]                word
);
    always_comb begin
        word = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < LANES; k++) begin
                word[k*W +: W] = word[k*W +: W] | lanes[r][k];
            end
        end
    end
endmodule

// File: rtl/wide_word_store.sv
module wide_word_store
    import wws_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SEL_W = 1;
    localparam int ROWS  = 1 << SEL_W;
    localparam int LO_W  = ADDR_W - SEL_W;
    localparam int LANES = DATA_W / LANE_W;

    ctl_t ctl_d, ctl_q;

    logic [ROWS-1:0]                       cs;
    logic [ROWS-1:0][LANES-1:0][LANE_W-1:0] lanes;
    logic [ROWS-1:0][LANES-1:0]            drv;
    logic [ROWS-1:0]                       row_drv;
    logic                                  oe_req;
    logic [DATA_W-1:0]                     bus;

    assign oe_req = rd_en && !wr_en;

    row_select #(.ROWS(ROWS), .SEL_W(SEL_W)) u_rsel (
        .sel    (req_addr[ADDR_W-1 -: SEL_W]),
        .active (rd_en || wr_en),
        .cs     (cs)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            byte_bank #(.AW(LO_W), .W(LANE_W)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .cs    (cs[r]),
                .we    (wr_en),
                .oe    (oe_req),
                .addr  (req_addr[LO_W-1:0]),
                .din   (wr_data[k*LANE_W +: LANE_W]),
                .lane  (lanes[r][k]),
                .drive (drv[r][k])
            );
        end
        assign row_drv[r] = |drv[r];
    end

    lane_merge #(.ROWS(ROWS), .LANES(LANES), .W(LANE_W)) u_merge (
        .lanes (lanes),
        .word  (bus)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.pend = oe_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_valid = ctl_q.pend && !wr_en;
    assign rd_data  = bus;
endmodule

// File: rtl/wide_word_store_chk.sv
module wide_word_store_chk #(
    parameter int DATA_W = 32,
    parameter int ROWS   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [ROWS-1:0]   row_drv
);
    p_wr_blanks_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_data == '0 && !rd_valid));

    p_idle_bus_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    p_valid_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en));

    p_req_gives_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (rd_valid || wr_en));

    p_collide_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> !rd_valid);

    p_one_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_drv));
endmodule

bind wide_word_store wide_word_store_chk #(.DATA_W(DATA_W), .ROWS(ROWS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .row_drv  (row_drv)
);

// File: tb/wide_word_store_tb.sv
module wide_word_store_tb;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int WORDS = 1 << AW;
    localparam logic [AW-1:0] TOP = AW'(1) << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [WORDS];
    logic          pend = 1'b0;
    logic [DW-1:0] pdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    wide_word_store #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_addr (req_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input int salt);
        logic [DW-1:0] p;
        p = {8'(a ^ 10'h3c5), 8'(a >> 2), 8'(salt), 8'(a)} ^ DW'(salt * 32'h9e3779b1);
        return p;
    endfunction

    task automatic check(input string req, input logic v, input logic [DW-1:0] d,
                         input logic ev, input logic [DW-1:0] ed);
        n_chk++;
        if (v !== ev || d !== ed) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, v, d, ev, ed);
        end
    endtask

    // one cycle: drive inputs, check outputs of this cycle, advance the model
    task automatic step(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                        input logic r, input string tag);
        logic          ev;
        logic [DW-1:0] ed;
        string         t;
        @(negedge clk);
        req_addr = a; wr_en = w; wr_data = d; rd_en = r;
        #1;
        ev = pend && !w;
        ed = ev ? pdata : '0;
        if (pend && w) t = "R7";
        else if (ev)   t = tag;
        else           t = "R5";
        check(t, rd_valid, rd_data, ev, ed);
        if (r && !w) begin pend = 1'b1; pdata = ref_mem[a]; end
        else pend = 1'b0;
        if (w) ref_mem[a] = d;
    endtask

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", rd_valid, rd_data, 1'b0, '0);
        step('0, 1'b0, '0, 1'b0, "R1");

        // fill every word so any later read is defined
        for (int i = 0; i < WORDS; i++) step(AW'(i), 1'b1, pattern(AW'(i), 1), 1'b0, "R2");

        // R3: same low bits, both rows, distinct words
        step(AW'(5), 1'b1, 32'h1111_2222, 1'b0, "R3");
        step(AW'(5) | TOP, 1'b1, 32'hAAAA_5555, 1'b0, "R3");
        step(AW'(5), 1'b0, '0, 1'b1, "R3");
        step(AW'(5) | TOP, 1'b0, '0, 1'b1, "R3"); // R8: rows alternate back to back
        step(AW'(5), 1'b0, '0, 1'b1, "R3");
        step('0, 1'b0, '0, 1'b0, "R3");

        // R4: distinct bytes per lane in both rows
        step(AW'(9), 1'b1, 32'hDE_AD_BE_EF, 1'b0, "R4");
        step(AW'(9) | TOP, 1'b1, 32'h01_23_45_67, 1'b0, "R4");
        step(AW'(9), 1'b0, '0, 1'b1, "R4");
        step(AW'(9) | TOP, 1'b0, '0, 1'b1, "R4");
        step('0, 1'b0, '0, 1'b0, "R4");

        // R6: read and write together, then confirm the write landed
        step(AW'(12), 1'b1, 32'hC0FF_EE00, 1'b1, "R6");
        step(AW'(12), 1'b0, '0, 1'b0, "R6");
        step(AW'(12), 1'b0, '0, 1'b1, "R6");
        step('0, 1'b0, '0, 1'b0, "R6");

        // R7: read, then a write in the cycle the result is due
        step(AW'(20), 1'b0, '0, 1'b1, "R7");
        step(AW'(21) | TOP, 1'b1, 32'h7777_0001, 1'b0, "R7");
        step(AW'(21) | TOP, 1'b0, '0, 1'b1, "R7");
        step('0, 1'b0, '0, 1'b0, "R7");

        // random traffic with frequent collisions
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic w, r;
            a = AW'($urandom);
            w = ($urandom % 100) < 35;
            r = ($urandom % 100) < 60;
            step(a, w, pattern(a, i + 7), r, "R2");
        end
        step('0, 1'b0, '0, 1'b0, "R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: valid=x data=x expected valid=run-complete data=x");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule